// File: doc/BRIEF.md
# Serial Control Slave for an Audio/Video Switch Matrix

This block is the write-only control port of an audio/video routing matrix. It watches a two-wire serial bus (I2C, standard mode, up to 100 kHz) with its own system clock. When a master addresses it at the fixed device address 7'b1001000 in write direction, it takes a register pointer byte and then any number of data bytes. Each data byte lands in the register the pointer names, and the pointer then steps forward. Three 8-bit control registers sit at pointers 01h, 02h and 03h.

The stored fields are decoded into ready-to-use controls: one-hot source selections for three video switches, two audio gain settings and one video gain setting in decibels, a three-level level-select code for a switching-signal output, mute flags for three video and three audio paths, and four general-purpose control bits. An external active-high mute pin joins the register mute bits on the audio paths. A power-save pin overrides the third video switch. The slave never drives data back and never stretches the clock. Its only bus output is the acknowledge pull-down on SDA.

Top module: `avsw_ctrl_slave`

## Requirements
- R1: Only a first byte equal to {7'b1001000, R/W=0} (90h) is acknowledged. Any other address, or R/W=1, gets no acknowledge on any byte, and no register changes until the next START.
- R2: After an accepted address, bytes arrive MSB first. The first byte is the register pointer and every later byte is data. Every byte of an accepted transfer is acknowledged.
- R3: The acknowledge pulls SDA low through the whole high phase of the 9th SCL clock. The pull-down starts and ends only while SCL is low, and it is released once a transfer has ended.
- R4: After each data byte the pointer advances by one, so consecutive bytes fill consecutive registers. A STOP after any complete data byte keeps every byte written so far.
- R5: A data byte whose pointer is outside 01h..03h is acknowledged but stored nowhere. The pointer stops at FFh and does not wrap around.
- R6: Register 01h: bits [1:0] set video switch 1 (00 source C, 01 source B, 10 and 11 source A), and bits [3:2] set video switch 2 (00 D, 01 C, 10 B, 11 A). Source outputs are one-hot with bit0=A, bit1=B, bit2=C and bit3=D.
- R7: Register 01h: bits [5:4] set video switch 3 (00 C, 01 B, 10 A, 11 no source, all bits 0). Bits [7:6] set the level code (00 and 01 HIGH=2, 10 MID=1, 11 LOW=0).
- R8: Register 02h: bits [2:0] are audio gain 1 (000/001/010/011/100 give 0/2/4/6/12 dB, and codes above 100 also give 12 dB). Bits [4:3] are audio gain 2 (code x 2 dB). Both are output as unsigned dB values.
- R9: Register 02h bit5 drives control bit 0, bit6 drives control bit 1, and bit7 selects video gain (0 gives 0 dB, 1 gives 6 dB). Register 03h bit6 drives control bit 2 and bit7 drives control bit 3.
- R10: Register 03h bits [2:0] mute video paths 1..3 and bits [5:3] mute audio paths 1..3 (1 mutes). Each audio mute is also forced on while the mute pin is high.
- R11: While the power-save pin is high, video switch 3 outputs source B, whatever its field holds.
- R12: After a synchronous active-low reset, all three registers read zero and SDA is released.
- R13: A START or STOP in the middle of a byte abandons that byte without writing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| mute_pin_i | input | 1 | External audio mute, active high |
| pwr_save_i | input | 1 | Power-save request, active high |
| vsw1_src_o | output | 4 | Video switch 1 source, one-hot {D,C,B,A} |
| vsw2_src_o | output | 4 | Video switch 2 source, one-hot {D,C,B,A} |
| vsw3_src_o | output | 4 | Video switch 3 source, one-hot or zero |
| lvl_sel_o | output | 2 | Level select: 2 HIGH, 1 MID, 0 LOW |
| again1_db_o | output | 4 | Audio gain 1 in dB |
| again2_db_o | output | 4 | Audio gain 2 in dB |
| vgain_db_o | output | 4 | Video gain in dB |
| gp_ctl_o | output | 4 | General-purpose control bits 0..3 |
| vmute_o | output | 3 | Video path mutes |
| amute_o | output | 3 | Audio path mutes |

## Verification
The main sweep sends 64 three-byte burst writes that start at pointer 01h. The data values are spread so that every code of every small field shows up. After each burst, all four combinations of the mute and power-save pins are applied. This separates the decode of each field from the pin overrides, and it shows whether auto-increment puts each byte in the right register. Separate transfers use a wrong address, a read direction, pointers 00h and 04h, a pointer near FFh and a single-byte write. These tell apart rejection, out-of-range discard, saturation and early STOP. A START and a STOP cut into a data byte show that partial bytes are dropped.

// File: rtl/avsw_pkg.sv
// Package: shared types and constants for the switch-matrix control slave.
// Assumes: byte-wide registers on a byte-wide bus.
package avsw_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,   // ignoring the bus until a START
        PH_ADDR,   // receiving device address
        PH_PTR,    // receiving register pointer
        PH_DATA    // receiving data bytes
    } bus_phase_t;
endpackage

// File: rtl/avsw_bus_sync.sv
// Module: avsw_bus_sync
// Brings SCL and SDA into the clock domain through a synchronizer chain and
// reports SCL edges plus START/STOP conditions seen on the synchronized lines.
// Assumes: STAGES >= 2; lines idle high.
module avsw_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains and one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/avsw_byte_engine.sv
// Module: avsw_byte_engine
// Bit/byte receiver and transfer sequencer: matches the device address,
// captures the register pointer, acknowledges bytes and issues one write
// strobe per complete data byte, advancing the pointer with saturation.
// Assumes: edge and condition pulses from avsw_bus_sync; write-only bus use.
module avsw_byte_engine
    import avsw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [3:0]        LAST_BIT = 4'(BYTE_W);
    localparam logic [3:0]        ACK_BIT  = 4'(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] PTR_MAX  = '1;

    bus_phase_t        phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr_q;

    // Transfer sequencing, bit shifting, acknowledge and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr_q    <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase    <= PH_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                phase    <= PH_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise && bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (scl_fall && bit_cnt == LAST_BIT) begin
                    bit_cnt <= ACK_BIT;
                    case (phase)
                        PH_ADDR: begin
                            if (shreg == {DEV_ADDR, 1'b0}) begin
                                sda_pull <= 1'b1;
                                phase    <= PH_PTR;
                            end else begin
                                phase    <= PH_IDLE;
                            end
                        end
                        PH_PTR: begin
                            sda_pull <= 1'b1;
                            ptr_q    <= shreg;
                            phase    <= PH_DATA;
                        end
                        default: begin
                            sda_pull <= 1'b1;
                            wr_en    <= 1'b1;
                            wr_addr  <= ptr_q;
                            wr_data  <= shreg;
                            if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 1'b1;
                        end
                    endcase
                end else if (scl_fall && bit_cnt == ACK_BIT) begin
                    sda_pull <= 1'b0;
                    bit_cnt  <= '0;
                end
            end
        end
    end

    // R3: the acknowledge pull-down only begins while SCL is low.
    p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R1: a rejected or finished transfer never holds SDA.
    p_idle_no_pull_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull);

    // R13: write strobes only follow a byte completed in the data phase.
    p_write_from_data_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(phase) == PH_DATA && !$past(start_det) && !$past(stop_det)));
endmodule

// File: rtl/avsw_ctrl_regs.sv
// Module: avsw_ctrl_regs
// Bank of control registers at consecutive pointers starting at FIRST_PTR;
// writes to any other pointer are discarded.
// Assumes: one-cycle write strobe from the byte engine.
module avsw_ctrl_regs
    import avsw_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 3,
    parameter int unsigned FIRST_PTR = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [BYTE_W-1:0]              wr_addr,
    input  logic [BYTE_W-1:0]              wr_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs_o
);
    localparam int unsigned LAST_PTR = FIRST_PTR + NUM_REGS - 1;

    logic hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // One register: cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) regs_o[i] <= '0;
            else if (wr_en && wr_addr == BYTE_W'(FIRST_PTR + i)) regs_o[i] <= wr_data;
        end
    end

    assign hit = wr_en && (32'(wr_addr) >= FIRST_PTR) && (32'(wr_addr) <= LAST_PTR);

    // R5: without an in-range write strobe no register moves.
    p_hold_without_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(regs_o));
endmodule

// File: rtl/avsw_field_decode.sv
// Module: avsw_field_decode
// Turns the three control bytes and the two override pins into source
// selections, gain values in dB, level code, mutes and control bits.
// Assumes: field layout as given in the brief.
module avsw_field_decode
    import avsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] route_reg,
    input  logic [BYTE_W-1:0] gain_reg,
    input  logic [BYTE_W-1:0] mute_reg,
    input  logic              mute_pin_i,
    input  logic              pwr_save_i,
    output logic [3:0]        vsw1_src_o,
    output logic [3:0]        vsw2_src_o,
    output logic [3:0]        vsw3_src_o,
    output logic [1:0]        lvl_sel_o,
    output logic [3:0]        again1_db_o,
    output logic [3:0]        again2_db_o,
    output logic [3:0]        vgain_db_o,
    output logic [3:0]        gp_ctl_o,
    output logic [2:0]        vmute_o,
    output logic [2:0]        amute_o
);
    localparam logic [3:0] SRC_A = 4'b0001;
    localparam logic [3:0] SRC_B = 4'b0010;
    localparam logic [3:0] SRC_C = 4'b0100;
    localparam logic [3:0] SRC_D = 4'b1000;

    // Source selection for the three video switches, with power-save override.
    always_comb begin
        case (route_reg[1:0])
            2'b00:   vsw1_src_o = SRC_C;
            2'b01:   vsw1_src_o = SRC_B;
            default: vsw1_src_o = SRC_A;
        endcase
        case (route_reg[3:2])
            2'b00:   vsw2_src_o = SRC_D;
            2'b01:   vsw2_src_o = SRC_C;
            2'b10:   vsw2_src_o = SRC_B;
            default: vsw2_src_o = SRC_A;
        endcase
        case (route_reg[5:4])
            2'b00:   vsw3_src_o = SRC_C;
            2'b01:   vsw3_src_o = SRC_B;
            2'b10:   vsw3_src_o = SRC_A;
            default: vsw3_src_o = 4'b0000;
        endcase
        if (pwr_save_i) vsw3_src_o = SRC_B;
    end

    // Three-level select code.
    always_comb begin
        case (route_reg[7:6])
            2'b10:   lvl_sel_o = 2'd1;
            2'b11:   lvl_sel_o = 2'd0;
            default: lvl_sel_o = 2'd2;
        endcase
    end

    // Gain values in dB.
    always_comb begin
        again1_db_o = (gain_reg[2:0] < 3'd4) ? {gain_reg[2:0], 1'b0} : 4'd12;
        again2_db_o = {1'b0, gain_reg[4:3], 1'b0};
        vgain_db_o  = gain_reg[7] ? 4'd6 : 4'd0;
    end

    // Control bits and mutes, audio mutes merged with the external pin.
    always_comb begin
        gp_ctl_o = {mute_reg[7], mute_reg[6], gain_reg[6], gain_reg[5]};
        vmute_o  = mute_reg[2:0];
        amute_o  = mute_reg[5:3] | {3{mute_pin_i}};
    end

    // R7: the third switch never selects more than one source.
    p_sw3_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vsw3_src_o));
endmodule

// File: rtl/avsw_ctrl_slave.sv
// Module: avsw_ctrl_slave (top)
// Write-only serial control slave for an audio/video switch matrix:
// synchronizer, byte engine, register bank and field decoder.
// Assumes: clk at least 16x faster than SCL; SDA is open-drain off chip.
module avsw_ctrl_slave
    import avsw_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'b1001000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FIRST_PTR   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       mute_pin_i,
    input  logic       pwr_save_i,
    output logic [3:0] vsw1_src_o,
    output logic [3:0] vsw2_src_o,
    output logic [3:0] vsw3_src_o,
    output logic [1:0] lvl_sel_o,
    output logic [3:0] again1_db_o,
    output logic [3:0] again2_db_o,
    output logic [3:0] vgain_db_o,
    output logic [3:0] gp_ctl_o,
    output logic [2:0] vmute_o,
    output logic [2:0] amute_o
);
    localparam int unsigned NUM_REGS = 3;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                           wr_en;
    logic [BYTE_W-1:0]              wr_addr, wr_data;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

    avsw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    avsw_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    avsw_ctrl_regs #(.NUM_REGS(NUM_REGS), .FIRST_PTR(FIRST_PTR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_o(regs)
    );

    avsw_field_decode u_decode (
        .clk(clk), .rst_n(rst_n),
        .route_reg(regs[0]), .gain_reg(regs[1]), .mute_reg(regs[2]),
        .mute_pin_i(mute_pin_i), .pwr_save_i(pwr_save_i),
        .vsw1_src_o(vsw1_src_o), .vsw2_src_o(vsw2_src_o), .vsw3_src_o(vsw3_src_o),
        .lvl_sel_o(lvl_sel_o), .again1_db_o(again1_db_o), .again2_db_o(again2_db_o),
        .vgain_db_o(vgain_db_o), .gp_ctl_o(gp_ctl_o),
        .vmute_o(vmute_o), .amute_o(amute_o)
    );
endmodule

// File: tb/tb_avsw_ctrl_slave.sv
// Bench for avsw_ctrl_slave: drives an open-drain bus model and checks every
// decoded output against a shadow register model built from the brief.
module tb_avsw_ctrl_slave;
    localparam int H = 10;  // clocks per SCL half phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic mute_pin = 1'b0, pwr_save = 1'b0;
    logic sda_pull;
    logic [3:0] vsw1, vsw2, vsw3, ag1, ag2, vg, gp;
    logic [1:0] lvl;
    logic [2:0] vm, am;
    wire sda_line = sda_m & ~sda_pull;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] shadow [4];  // index 1..3 used

    always #4 clk = ~clk;

    avsw_ctrl_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .mute_pin_i(mute_pin), .pwr_save_i(pwr_save),
        .vsw1_src_o(vsw1), .vsw2_src_o(vsw2), .vsw3_src_o(vsw3),
        .lvl_sel_o(lvl), .again1_db_o(ag1), .again2_db_o(ag2),
        .vgain_db_o(vg), .gp_ctl_o(gp), .vmute_o(vm), .amute_o(am)
    );

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H); scl_m = 1'b0; hold(2);
    endtask

    task automatic bus_stop();
        hold(2); sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            hold(2); sda_m = b[7-i]; hold(H);
            scl_m = 1'b1; hold(H); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        hold(2); sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H/2);
        acked = !sda_line;
        hold(H/2); scl_m = 1'b0;
    endtask

    // Full transfer; shadow model follows R1, R4, R5 independently of the RTL.
    task automatic xfer(input logic [7:0] first, input logic [7:0] ptr,
                        input logic [7:0] d [4], input int nd, output int acks);
        bit a;
        int p;
        acks = 0;
        bus_start();
        send_byte(first, a); acks += int'(a);
        send_byte(ptr, a);   acks += int'(a);
        for (int k = 0; k < nd; k++) begin
            send_byte(d[k], a); acks += int'(a);
        end
        bus_stop();
        if (first == 8'h90) begin
            p = int'(ptr);
            for (int k = 0; k < nd; k++) begin
                if (p >= 1 && p <= 3) shadow[p] = d[k];
                if (p != 255) p++;
            end
        end
    endtask

    function automatic logic [3:0] onehot_idx(input int idx);
        return (idx < 0) ? 4'b0000 : 4'(1 << idx);
    endfunction

    // Compare all decoded outputs with values computed from the shadow model.
    task automatic check_all(input string tag);
        logic [7:0] r1, r2, r3;
        int c;
        r1 = shadow[1]; r2 = shadow[2]; r3 = shadow[3];
        c = int'(r1[1:0]);
        chk({tag, " R6 vsw1"}, 32'(vsw1), 32'(onehot_idx((c >= 2) ? 0 : 2 - c)));
        c = int'(r1[3:2]);
        chk({tag, " R6 vsw2"}, 32'(vsw2), 32'(onehot_idx(3 - c)));
        c = int'(r1[5:4]);
        if (pwr_save) chk({tag, " R11 vsw3"}, 32'(vsw3), 32'(onehot_idx(1)));
        else chk({tag, " R7 vsw3"}, 32'(vsw3), 32'(onehot_idx((c == 3) ? -1 : 2 - c)));
        c = int'(r1[7:6]);
        chk({tag, " R7 lvl"}, 32'(lvl), 32'((c <= 1) ? 2 : 3 - c));
        c = int'(r2[2:0]);
        chk({tag, " R8 gain1"}, 32'(ag1), 32'((c < 4) ? 2 * c : 12));
        chk({tag, " R8 gain2"}, 32'(ag2), 32'(2 * int'(r2[4:3])));
        chk({tag, " R9 vgain"}, 32'(vg), 32'(6 * int'(r2[7])));
        chk({tag, " R9 ctl"}, 32'(gp), 32'({r3[7], r3[6], r2[6], r2[5]}));
        chk({tag, " R10 vmute"}, 32'(vm), 32'(r3[2:0]));
        chk({tag, " R10 amute"}, 32'(am), 32'(mute_pin ? 3'b111 : r3[5:3]));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [4];
        int acks;
        for (int k = 0; k < 4; k++) shadow[k] = 8'h00;
        hold(5);
        rst_n = 1'b1;
        hold(3);
        // R12: reset state.
        chk("R12 sda released", 32'(sda_pull), 32'd0);
        check_all("R12 reset");

        // Main sweep: burst of three bytes from pointer 01h, all pin combos.
        for (int i = 0; i < 64; i++) begin
            d[0] = 8'((i * 53 + 7) & 255);
            d[1] = 8'((i * 29 + 3) & 255);
            d[2] = 8'((i * 101 + 11) & 255);
            d[3] = 8'h00;
            xfer(8'h90, 8'h01, d, 3, acks);
            chk("R2 R4 burst acks", 32'(acks), 32'd5);
            chk("R3 released after transfer", 32'(sda_pull), 32'd0);
            for (int p = 0; p < 4; p++) begin
                mute_pin = p[0];
                pwr_save = p[1];
                hold(2);
                check_all("sweep");
            end
            mute_pin = 1'b0;
            pwr_save = 1'b0;
        end

        // R1: wrong address, then read direction: no ack, no change.
        d[0] = 8'hFF; d[1] = 8'hFF; d[2] = 8'hFF; d[3] = 8'hFF;
        xfer(8'h92, 8'h01, d, 3, acks);
        chk("R1 wrong address acks", 32'(acks), 32'd0);
        check_all("R1 wrong address");
        xfer(8'h91, 8'h01, d, 3, acks);
        chk("R1 read direction acks", 32'(acks), 32'd0);
        check_all("R1 read direction");

        // R5: pointer 04h is out of range but acknowledged.
        d[0] = 8'hA5; d[1] = 8'h5A;
        xfer(8'h90, 8'h04, d, 2, acks);
        chk("R5 out-of-range acks", 32'(acks), 32'd4);
        check_all("R5 pointer 04");

        // R4 R5: pointer 00h discards, next byte lands in 01h.
        d[0] = 8'h3C; d[1] = 8'b10_10_01_00;
        xfer(8'h90, 8'h00, d, 2, acks);
        chk("R4 pointer 00 acks", 32'(acks), 32'd4);
        check_all("R4 pointer 00 then 01");

        // R5: saturation at FFh, no wrap into 00h..03h.
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
        xfer(8'h90, 8'hFE, d, 4, acks);
        chk("R5 saturation acks", 32'(acks), 32'd6);
        check_all("R5 saturation");

        // R4: STOP after one data byte writes only that register.
        d[0] = 8'b1_0_0_11_100;
        xfer(8'h90, 8'h02, d, 1, acks);
        chk("R4 single byte acks", 32'(acks), 32'd3);
        check_all("R4 single byte");

        // R13: repeated START in the middle of a data byte.
        begin
            bit a;
            bus_start();
            send_byte(8'h90, a);
            send_byte(8'h03, a);
            send_bits(8'hFF, 4);
            bus_start();
            bus_stop();
            hold(4);
            check_all("R13 start mid-byte");
            // R13: STOP in the middle of a data byte.
            bus_start();
            send_byte(8'h90, a);
            send_byte(8'h01, a);
            send_bits(8'h00, 5);
            bus_stop();
            hold(4);
            check_all("R13 stop mid-byte");
            chk("R3 released after abort", 32'(sda_pull), 32'd0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule